// File: doc/BRIEF.md
# Pulse-Per-Second Timing Aligner

This block produces a 10 ms processing strobe and a one-second strobe from a timebase that free-runs on the system clock. It can also lock that timebase to an external once-per-second reference pulse. The reference arrives asynchronously. It is brought into the clock domain through a short flop chain, and its low-to-high transitions are detected there.

A detected rising edge is used only when it lies close to the point where the internal second is expected to roll over. The accepted band is one tenth of a second on either side of that point. An accepted edge restarts the second and the 10 ms grid on that very cycle. A status output shows whether the timebase is currently disciplined by the reference. It reports loss of discipline once two internal seconds in a row have passed without an accepted edge. The clock rate is a parameter. All cycle counts are derived from it.

Top module: `pps_aligner`

## Requirements
- R1: During reset and in the first cycle after reset, `unlocked` is 1 and both strobes are 0. The timebase starts at phase 0. The phase is the number of cycles since the current second began.
- R2: Without accepted edges, `tickTen` pulses once every CLK_HZ/100 cycles. The first pulse comes in the cycle at phase CLK_HZ/100 - 1 after reset.
- R3: Without accepted edges, `tickSec` pulses in the cycle at phase SEC-1 and then every SEC cycles, where SEC = 100*(CLK_HZ/100). `tickTen` is also high in every `tickSec` cycle.
- R4: A transition of `ppsAsync` from low to high is acted on two cycles after the cycle in which it was driven. The input must be set up before a clock edge. A transition from high to low, or a steady level, never changes the timebase.
- R5: An edge seen while the phase is at most WIN = SEC/10, or at least SEC-WIN, is accepted. In that cycle `tickTen` and `tickSec` are both 1. The next cycle has phase 0, so the next `tickSec` follows exactly SEC cycles later.
- R6: An edge seen at any other phase is ignored. It produces no strobe and leaves the phase and `unlocked` unchanged.
- R7: `unlocked` is 0 from the cycle after an accepted edge.
- R8: `unlocked` becomes 1 in the cycle after the second consecutive natural `tickSec` with no accepted edge in between. The timebase keeps counting from its current phase.
- R9: Each strobe is high for one cycle. `tickTen` can be high in two consecutive cycles only when the second of them carries an accepted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ppsAsync | input | 1 | External once-per-second reference, asynchronous |
| tickTen | output | 1 | One-cycle strobe every 10 ms |
| tickSec | output | 1 | One-cycle strobe at each second boundary |
| unlocked | output | 1 | 1 when the timebase is not disciplined by the reference |

## Verification
The hardest cases to reach from the ports are edges that land exactly on the window limits, one cycle inside and one cycle outside. The synchronizer delay lies between the input and the phase comparison, so an edge cannot simply be placed at a chosen phase. The bench tracks the expected phase itself and raises the input two cycles before the target phase. It does this at phases WIN, WIN+1, SEC-WIN-1 and SEC-WIN, and for a falling edge placed inside the window. Random reference periods spread around one second then mix accepted and rejected edges with loss and recovery of lock.

// File: rtl/pps_align_pkg.sv
package pps_align_pkg;

  // Strobes issued by the lock control toward the timebase datapath.
  typedef struct packed {
    logic realign;
  } ctrl_strobes_t;

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ppsAsync,
  output logic riseSeen
);

  logic [STAGES-1:0] chain;
  logic              prevQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= ppsAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevQ <= 1'b0;
    else     prevQ <= chain[STAGES-1];
  end

  assign riseSeen = chain[STAGES-1] & ~prevQ;

endmodule

// File: rtl/pps_timebase_dp.sv
module pps_timebase_dp
  import pps_align_pkg::*;
#(
  parameter int TEN = 20,
  parameter int SEC = 2000,
  parameter int PW  = $clog2(SEC),
  parameter int SW  = $clog2(TEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_strobes_t strobes,
  output logic [PW-1:0] phaseCnt,
  output logic [SW-1:0] subCnt,
  output logic          secWrap,
  output logic          tickTen,
  output logic          tickSec
);

  logic subWrap;

  assign subWrap = (subCnt == SW'(TEN - 1));
  assign secWrap = (phaseCnt == PW'(SEC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      subCnt   <= '0;
      phaseCnt <= '0;
    end else if (strobes.realign) begin
      subCnt   <= '0;
      phaseCnt <= '0;
    end else begin
      subCnt   <= subWrap ? '0 : subCnt + 1'b1;
      phaseCnt <= secWrap ? '0 : phaseCnt + 1'b1;
    end
  end

  assign tickTen = strobes.realign | subWrap;
  assign tickSec = strobes.realign | secWrap;

endmodule

// File: rtl/pps_lock_ctrl.sv
module pps_lock_ctrl
  import pps_align_pkg::*;
#(
  parameter int SEC = 2000,
  parameter int WIN = 200,
  parameter int PW  = $clog2(SEC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          riseSeen,
  input  logic [PW-1:0] phaseCnt,
  input  logic          secWrap,
  output ctrl_strobes_t strobes,
  output logic          unlocked
);

  logic inWindow;
  logic missedOne;

  assign inWindow = (phaseCnt <= PW'(WIN)) || (phaseCnt >= PW'(SEC - WIN));

  always_comb begin
    strobes         = '0;
    strobes.realign = riseSeen & inWindow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      missedOne <= 1'b0;
      unlocked  <= 1'b1;
    end else if (strobes.realign) begin
      missedOne <= 1'b0;
      unlocked  <= 1'b0;
    end else if (secWrap) begin
      if (missedOne) unlocked <= 1'b1;
      missedOne <= 1'b1;
    end
  end

endmodule

// File: rtl/pps_aligner.sv
module pps_aligner
  import pps_align_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ppsAsync,
  output logic tickTen,
  output logic tickSec,
  output logic unlocked
);

  localparam int TEN = CLK_HZ / 100;
  localparam int SEC = TEN * 100;
  localparam int WIN = TEN * 10;
  localparam int PW  = $clog2(SEC);
  localparam int SW  = $clog2(TEN);

  logic          riseSeen;
  logic [PW-1:0] phaseCnt;
  logic [SW-1:0] subCnt;
  logic          secWrap;
  ctrl_strobes_t strobes;

  pps_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .ppsAsync (ppsAsync),
    .riseSeen (riseSeen)
  );

  pps_lock_ctrl #(.SEC(SEC), .WIN(WIN), .PW(PW)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .riseSeen (riseSeen),
    .phaseCnt (phaseCnt),
    .secWrap  (secWrap),
    .strobes  (strobes),
    .unlocked (unlocked)
  );

  pps_timebase_dp #(.TEN(TEN), .SEC(SEC), .PW(PW), .SW(SW)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .phaseCnt (phaseCnt),
    .subCnt   (subCnt),
    .secWrap  (secWrap),
    .tickTen  (tickTen),
    .tickSec  (tickSec)
  );

endmodule

// File: rtl/pps_aligner_chk.sv
module pps_aligner_chk
  import pps_align_pkg::*;
#(
  parameter int TEN = 20,
  parameter int SW  = $clog2(TEN)
) (
  input logic          clk,
  input logic          rst,
  input logic          tickTen,
  input logic          tickSec,
  input logic          unlocked,
  input logic          riseSeen,
  input logic [SW-1:0] subCnt,
  input ctrl_strobes_t strobes
);

  // R9: a second consecutive 10 ms strobe needs an accepted edge
  a_r9_ten_single: assert property (@(posedge clk) disable iff (rst)
    tickTen |=> (!tickTen || strobes.realign));

  // R3: every second strobe coincides with a 10 ms strobe
  a_r3_sec_with_ten: assert property (@(posedge clk) disable iff (rst)
    tickSec |-> tickTen);

  // R7: lock indication follows an accepted edge
  a_r7_clear_after_accept: assert property (@(posedge clk) disable iff (rst)
    strobes.realign |=> !unlocked);

  // R4: realignment only on a detected rising edge
  a_r4_accept_needs_rise: assert property (@(posedge clk) disable iff (rst)
    strobes.realign |-> riseSeen);

  // R8: loss of lock is only declared right after a second boundary
  a_r8_set_at_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(tickSec));

  // R2: the 10 ms sub-counter stays inside its range
  a_r2_sub_bound: assert property (@(posedge clk) disable iff (rst)
    subCnt <= SW'(TEN - 1));

endmodule

bind pps_aligner pps_aligner_chk #(.TEN(TEN), .SW(SW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tickTen  (tickTen),
  .tickSec  (tickSec),
  .unlocked (unlocked),
  .riseSeen (riseSeen),
  .subCnt   (subCnt),
  .strobes  (strobes)
);

// File: tb/pps_aligner_tb.sv
module pps_aligner_tb_top;

  localparam int CLK_HZ_TB = 2000;
  localparam int TEN = CLK_HZ_TB / 100;
  localparam int SEC = TEN * 100;
  localparam int WIN = TEN * 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ppsAsync = 1'b0;
  logic tickTen, tickSec, unlocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected state derived from the requirements
  int mPhase = 0, mSub = 0;
  bit mUnl = 1, mMissed = 0, mS1 = 0, mS2 = 0, mPv = 0, prevTen = 0;
  bit curPps = 0;

  always #4 clk = ~clk;

  pps_aligner #(.CLK_HZ(CLK_HZ_TB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .ppsAsync(ppsAsync),
    .tickTen(tickTen), .tickSec(tickSec), .unlocked(unlocked)
  );

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic bit inWin(input int p);
    return (p <= WIN) || (p >= SEC - WIN);
  endfunction

  // Compare this cycle, drive the input for the next edge, advance the model.
  task automatic step(input bit nextPps, input string tag);
    bit expEdge, expRealign, expTen, expSec;
    expEdge    = mS2 && !mPv;
    expRealign = expEdge && inWin(mPhase);
    expTen     = expRealign || (mSub == TEN - 1);
    expSec     = expRealign || (mPhase == SEC - 1);
    check(tickTen === expTen, {tag, " R2 tickTen"}, int'(tickTen), int'(expTen));
    check(tickSec === expSec, {tag, " R3 tickSec"}, int'(tickSec), int'(expSec));
    check(unlocked === mUnl, mUnl ? "R8 unlocked" : "R7 unlocked", int'(unlocked), int'(mUnl));
    if (prevTen)
      check(!tickTen || expRealign, "R9 tickTen width", int'(tickTen), 0);
    prevTen = tickTen;
    if (expRealign) begin
      mPhase = 0; mSub = 0; mMissed = 0; mUnl = 0;
    end else begin
      if (mPhase == SEC - 1) begin
        if (mMissed) mUnl = 1;
        mMissed = 1;
      end
      mPhase = (mPhase + 1) % SEC;
      mSub   = (mSub + 1) % TEN;
    end
    mPv = mS2; mS2 = mS1; mS1 = nextPps;
    ppsAsync = nextPps;
    curPps = nextPps;
    @(negedge clk);
  endtask

  // Advance so that a level change driven now is seen at phase p.
  task automatic moveTo(input int p);
    int tgt;
    tgt = (p + SEC - 2) % SEC;
    while (mPhase != tgt) step(curPps, "move");
  endtask

  task automatic changeAt(input int p, input bit lvl);
    moveTo(p);
    step(lvl, "R4");
    step(lvl, "R4");
  endtask

  task automatic finishPulse();
    repeat (8) step(1, "R4");
    curPps = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(unlocked === 1'b1, "R1 unlocked after reset", int'(unlocked), 1);
    check(tickTen === 1'b0 && tickSec === 1'b0, "R1 strobes after reset", int'(tickTen | tickSec), 0);

    // R2 / R3: free-running strobes
    repeat (TEN - 1) step(0, "R2");
    check(tickTen === 1'b1, "R2 first tickTen", int'(tickTen), 1);
    while (mPhase != SEC - 1) step(0, "R3");
    check(tickSec === 1'b1 && tickTen === 1'b1, "R3 first tickSec", int'(tickSec), 1);
    step(0, "R3");

    // R6: one cycle past the early window limit
    changeAt(WIN + 1, 1'b1);
    check(tickSec === 1'b0 && tickTen === 1'b0, "R6 edge at WIN+1 ignored", int'(tickSec), 0);
    finishPulse();
    check(unlocked === 1'b1, "R6 unlocked unchanged", int'(unlocked), 1);

    // R5: edge on the early window limit, R7 lock
    changeAt(WIN, 1'b1);
    check(tickSec === 1'b1 && tickTen === 1'b1, "R5 edge at WIN accepted", int'(tickSec), 1);
    n = 0;
    do begin
      step(n < 8, "R5");
      if (n == 0) check(unlocked === 1'b0, "R7 locked after accept", int'(unlocked), 0);
      n++;
    end while (tickSec !== 1'b1 && n < 3 * SEC);
    curPps = 0;
    check(n == SEC, "R5 second period after realign", n, SEC);

    // R6: one cycle before the late window limit
    changeAt(SEC - WIN - 1, 1'b1);
    check(tickSec === 1'b0, "R6 edge at SEC-WIN-1 ignored", int'(tickSec), 0);
    finishPulse();
    check(unlocked === 1'b0, "R6 lock unchanged", int'(unlocked), 0);

    // R5: edge on the late window limit
    changeAt(SEC - WIN, 1'b1);
    check(tickSec === 1'b1 && tickTen === 1'b1, "R5 edge at SEC-WIN accepted", int'(tickSec), 1);
    finishPulse();

    // R4: rise outside the window, fall inside it
    changeAt(500, 1'b1);
    check(tickSec === 1'b0, "R4 rise at 500 ignored", int'(tickSec), 0);
    changeAt(1950, 1'b0);
    check(tickSec === 1'b0 && tickTen === 1'b0, "R4 falling edge ignored", int'(tickSec), 0);

    // R8: loss of lock after two empty seconds
    changeAt(WIN, 1'b1);
    check(tickSec === 1'b1, "R8 setup accept", int'(tickSec), 1);
    finishPulse();
    repeat (SEC - 4) step(0, "R8");
    check(unlocked === 1'b0, "R8 still locked after one second", int'(unlocked), 0);
    repeat (SEC) step(0, "R8");
    check(unlocked === 1'b1, "R8 unlocked after two seconds", int'(unlocked), 1);

    // random reference periods around one second
    for (int k = 0; k < 25; k++) begin
      int w, per;
      w   = $urandom_range(1, 100);
      per = SEC + $urandom_range(0, 600) - 300;
      repeat (w) step(1, "rand");
      repeat (per - w) step(0, "rand");
    end
    repeat (3 * SEC) step(0, "rand");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule